// File: doc/BRIEF.md
# Alignment Score Matrix Engine

This block fills the score matrix used in global sequence alignment. The matrix is square, with COLS rows and COLS columns, and is held in registers addressed by a flat row-major index: cell (row, col) sits at row*COLS + col. Software first loads the border cells of row 0 and column 0, plus one reference score for each cell, through a single load port. It then pulses start. The engine sweeps the upper-left triangle of the matrix one anti-diagonal at a time and computes exactly one cell per clock. Each new value is the best of three moves: a diagonal step plus the cell's reference score, a step from the left minus the gap penalty, and a step from above minus the gap penalty.

The sequencer keeps two counters, a diagonal number i and a step number idx along that diagonal. From them it forms one write address per cycle, (idx + 1) * COLS + (i + 1 - idx). A single evaluator and a single write port serve every cell, so no storage word has more than one driver. When the last cell of the triangle has been written, a one-cycle done pulse follows. The matrix can be read at any time through a combinational read port.

Top module: `sa_score_engine`

## Requirements
- R1: After reset, done is 0 and every matrix cell reads as 0 on rd_data.
- R2: While idle, a cycle with ld_en=1 and ld_sel=0 writes ld_data into the matrix cell at ld_addr. The new value shows on rd_data for that address from the next cycle on.
- R3: While idle, a cycle with ld_en=1 and ld_sel=1 writes ld_data into the reference score at ld_addr. No matrix cell read through rd_data changes.
- R4: Each swept cell at address a receives the signed maximum of M[a-1-COLS]+S[a], M[a-1]-P and M[a-COLS]-P. M is the matrix, S is the reference score and P is the penalty. All sums wrap in 16-bit two's complement.
- R5: Diagonals i = 0 up to COLS-2 are swept in increasing order, with idx = 0..i inside each one, at one cell per cycle. done is high for exactly one cycle, COLS*(COLS-1)/2 cycles after the cycle in which start was accepted.
- R6: Cells in row 0, in column 0, and those with row+col > COLS keep their loaded values across a sweep.
- R7: A start pulse while a sweep is running is ignored. The sweep timing and its result are unchanged, and no extra done pulse appears.
- R8: Loads of either kind are ignored while a sweep is running.
- R9: The penalty is captured in the cycle start is accepted. Changes on penalty during the sweep have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| penalty | input | 16 | Signed gap penalty, captured on start |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 1 | Load target: 0 matrix cell, 1 reference score |
| ld_addr | input | $clog2(COLS*COLS) | Flat row-major load address |
| ld_data | input | 16 | Signed value to load |
| rd_addr | input | $clog2(COLS*COLS) | Flat row-major read address |
| rd_data | output | 16 | Signed matrix cell at rd_addr |
| done | output | 1 | One-cycle pulse after the last cell is written |

## Verification
Two events can land in the same cycle as a running sweep: a new start pulse, and a load from the load port, which would compete with the engine's own write. The bench injects each one at a fixed cycle offset in the middle of a sweep. It aims the loads at a border cell and at the reference score of the very last swept cell, so an accepted load would change the result. Each case is judged two ways: done must arrive on exactly the expected cycle with no second pulse, and the full matrix must match a behavioural model that ignores the injected event. A change of penalty during the sweep is judged the same way.

// File: rtl/sa_pkg.sv
package sa_pkg;
  parameter int SCORE_W = 16;
  typedef logic signed [SCORE_W-1:0] score_t;
endpackage

// File: rtl/sa_sequencer.sv
module sa_sequencer #(
  parameter int COLS = 8,
  parameter int AW   = $clog2(COLS*COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          eng_we,
  output logic [AW-1:0] eng_addr
);
  localparam int DW = (COLS > 2) ? $clog2(COLS) : 1;
  localparam logic [DW-1:0] DIAG_LAST = DW'(COLS - 2);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [DW-1:0] diag_q, diag_d;
  logic [DW-1:0] step_q, step_d;
  logic          last_step, last_cell;

  assign last_step = (step_q == diag_q);
  assign last_cell = last_step && (diag_q == DIAG_LAST);

  always_comb begin
    busy_d = busy_q;
    diag_d = diag_q;
    step_d = step_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        diag_d = '0;
        step_d = '0;
      end
    end else if (last_step) begin
      step_d = '0;
      if (last_cell) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        diag_d = diag_q + DW'(1);
      end
    end else begin
      step_d = step_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      diag_q <= '0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      diag_q <= diag_d;
      step_q <= step_d;
    end
  end

  // row = idx + 1, col = i + 1 - idx
  assign eng_addr = (AW'(step_q) + AW'(1)) * AW'(COLS)
                  + AW'(diag_q) + AW'(1) - AW'(step_q);
  assign eng_we   = busy_q;
  assign busy     = busy_q;
  assign done     = done_q;

  // R5: counters stay inside the triangle
  p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_q <= diag_q) && (diag_q <= DIAG_LAST));

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: start during a sweep does not restart it
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last_cell) |=> !((diag_q == '0) && (step_q == '0)));
endmodule

// File: rtl/sa_cell_pe.sv
module sa_cell_pe
  import sa_pkg::*;
(
  input  score_t diag_v,
  input  score_t left_v,
  input  score_t up_v,
  input  score_t ref_v,
  input  score_t pen,
  output score_t best
);
  score_t cand_d, cand_l, cand_u, top2;

  always_comb begin
    cand_d = diag_v + ref_v;
    cand_l = left_v - pen;
    cand_u = up_v - pen;
    top2   = (cand_l > cand_d) ? cand_l : cand_d;
    best   = (cand_u > top2) ? cand_u : top2;
    // R4: result bounds every candidate and is one of them
    p_best_bound_r4: assert ((best >= cand_d) && (best >= cand_l) && (best >= cand_u)
                             && ((best == cand_d) || (best == cand_l) || (best == cand_u)));
  end
endmodule

// File: rtl/sa_score_store.sv
module sa_score_store
  import sa_pkg::*;
#(
  parameter int COLS = 8,
  parameter int N    = COLS*COLS,
  parameter int AW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  score_t        ld_data,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  score_t        eng_val,
  input  logic [AW-1:0] rd_addr,
  output score_t        rd_data,
  output score_t        nb_diag,
  output score_t        nb_left,
  output score_t        nb_up,
  output score_t        ref_v
);
  score_t mat [N];
  score_t rsc [N];

  for (genvar e = 0; e < N; e++) begin : g_entry
    logic   cell_we, ref_we;
    score_t cell_d;
    score_t cell_q, ref_q;

    assign cell_we = (eng_we && (eng_addr == AW'(e)))
                  || (ld_we && !ld_sel && (ld_addr == AW'(e)));
    assign ref_we  = ld_we && ld_sel && (ld_addr == AW'(e));
    assign cell_d  = eng_we ? eng_val : ld_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
        ref_q  <= '0;
      end else begin
        if (cell_we) cell_q <= cell_d;
        if (ref_we)  ref_q  <= ld_data;
      end
    end

    assign mat[e] = cell_q;
    assign rsc[e] = ref_q;
  end

  assign rd_data = mat[rd_addr];
  assign nb_diag = mat[eng_addr - AW'(COLS) - AW'(1)];
  assign nb_left = mat[eng_addr - AW'(1)];
  assign nb_up   = mat[eng_addr - AW'(COLS)];
  assign ref_v   = rsc[eng_addr];

  // R8: a load never coincides with an engine write
  p_single_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_we && ld_we));

  // R6: engine writes avoid row 0 and column 0
  p_border_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (eng_addr >= AW'(COLS)) && ((eng_addr % AW'(COLS)) != '0));
endmodule

// File: rtl/sa_score_engine.sv
module sa_score_engine
  import sa_pkg::*;
#(
  parameter int COLS = 8,
  localparam int N   = COLS*COLS,
  localparam int AW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  score_t        penalty,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  score_t        ld_data,
  input  logic [AW-1:0] rd_addr,
  output score_t        rd_data,
  output logic          done
);
  logic          busy, eng_we, ld_we, accept;
  logic [AW-1:0] eng_addr;
  score_t        pen_q, pen_d;
  score_t        nb_diag, nb_left, nb_up, ref_v, best;

  assign accept = start && !busy;
  assign ld_we  = ld_en && !busy;
  assign pen_d  = accept ? penalty : pen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pen_q <= '0;
    else        pen_q <= pen_d;
  end

  sa_sequencer #(.COLS(COLS), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .eng_we(eng_we), .eng_addr(eng_addr)
  );

  sa_score_store #(.COLS(COLS), .N(N), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .eng_we(eng_we), .eng_addr(eng_addr), .eng_val(best),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .nb_diag(nb_diag), .nb_left(nb_left), .nb_up(nb_up), .ref_v(ref_v)
  );

  sa_cell_pe u_pe (
    .diag_v(nb_diag), .left_v(nb_left), .up_v(nb_up),
    .ref_v(ref_v), .pen(pen_q), .best(best)
  );

  // R9: penalty held constant for the whole sweep
  p_pen_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pen_q));
endmodule

// File: tb/sa_score_engine_tb.sv
module sa_score_engine_tb;
  localparam int COLS = 8;
  localparam int N    = COLS*COLS;
  localparam int AW   = $clog2(N);
  localparam int NCELLS = COLS*(COLS-1)/2;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                start, ld_en, ld_sel;
  logic signed [15:0]  penalty, ld_data, rd_data;
  logic [AW-1:0]       ld_addr, rd_addr;
  logic                done;

  int checks = 0;
  int errors = 0;

  logic signed [15:0] init_m [N];
  logic signed [15:0] ref_m  [N];
  logic signed [15:0] exp_m  [N];

  always #5 clk = ~clk;

  sa_score_engine #(.COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .penalty(penalty),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic signed [15:0] max3(input logic signed [15:0] a,
      input logic signed [15:0] b, input logic signed [15:0] c);
    logic signed [15:0] m;
    m = (a > b) ? a : b;
    return (c > m) ? c : m;
  endfunction

  task automatic model(input logic signed [15:0] pen);
    logic signed [15:0] d, l, u;
    for (int a = 0; a < N; a++) exp_m[a] = init_m[a];
    for (int t = 2; t <= COLS; t++)
      for (int r = 1; r < t; r++) begin
        int a;
        a = r*COLS + (t - r);
        d = exp_m[a-COLS-1] + ref_m[a];
        l = exp_m[a-1] - pen;
        u = exp_m[a-COLS] - pen;
        exp_m[a] = max3(d, l, u);
      end
  endtask

  task automatic load(input logic sel, input int addr, input logic signed [15:0] v);
    ld_en = 1'b1; ld_sel = sel; ld_addr = AW'(addr); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic read(input int addr, output logic signed [15:0] v);
    rd_addr = AW'(addr);
    #1;
    v = rd_data;
  endtask

  task automatic load_all();
    for (int a = 0; a < N; a++) load(1'b0, a, init_m[a]);
    for (int a = 0; a < N; a++) load(1'b1, a, ref_m[a]);
  endtask

  // mode 0 plain, 1 start mid-run, 2 loads mid-run, 3 penalty change mid-run
  task automatic sweep(input int mode, input logic signed [15:0] pen);
    int dones;
    logic signed [15:0] v;
    dones = 0;
    model(pen);
    penalty = pen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= NCELLS + 8; k++) begin
      start = (mode == 1) && (k == 5);
      ld_en = (mode == 2) && ((k == 5) || (k == 7));
      ld_sel = (k == 7);
      ld_addr = (k == 7) ? AW'((COLS-1)*COLS + 1) : AW'(0);
      ld_data = 16'sh1234;
      if (mode == 3 && k == 3) penalty = -pen + 16'sd7;
      @(negedge clk);
      if (done) dones++;
      if (k == NCELLS) chk($sformatf("R5 done at cycle %0d mode %0d", k, mode), int'(done), 1);
      else if (k < NCELLS) begin
        if (done) chk($sformatf("R5 early done cycle %0d", k), int'(done), 0);
      end
    end
    start = 1'b0; ld_en = 1'b0;
    if (mode == 1) chk("R7 single done after mid-run start", dones, 1);
    else           chk($sformatf("R5 done count mode %0d", mode), dones, 1);
    for (int a = 0; a < N; a++) begin
      int r, c;
      r = a / COLS; c = a % COLS;
      read(a, v);
      if (r == 0 || c == 0 || r + c > COLS)
        chk($sformatf("R6 kept cell %0d mode %0d", a, mode), int'(v), int'(exp_m[a]));
      else if (mode == 1)
        chk($sformatf("R7 cell %0d", a), int'(v), int'(exp_m[a]));
      else if (mode == 2)
        chk($sformatf("R8 cell %0d", a), int'(v), int'(exp_m[a]));
      else if (mode == 3)
        chk($sformatf("R9 cell %0d", a), int'(v), int'(exp_m[a]));
      else
        chk($sformatf("R4 cell %0d", a), int'(v), int'(exp_m[a]));
    end
  endtask

  task automatic fill_random(input int span);
    for (int a = 0; a < N; a++) begin
      init_m[a] = (span == 0) ? 16'($urandom) : 16'($signed($urandom % span) - span/2);
      ref_m[a]  = (span == 0) ? 16'($urandom) : 16'($signed($urandom % span) - span/2);
    end
  endtask

  initial begin
    logic signed [15:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; penalty = '0; ld_en = 1'b0; ld_sel = 1'b0;
    ld_addr = '0; ld_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done after reset", int'(done), 0);
    for (int a = 0; a < N; a += 9) begin
      read(a, v);
      chk($sformatf("R1 cell %0d after reset", a), int'(v), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: loads while idle
    load(1'b0, 10, 16'sd77);
    read(10, v);
    chk("R2 matrix load visible", int'(v), 77);
    load(1'b1, 10, -16'sd5);
    read(10, v);
    chk("R3 ref load leaves matrix cell", int'(v), 77);
    load(1'b1, 3, 16'sd99);
    read(3, v);
    chk("R3 ref load leaves untouched cell", int'(v), 0);

    // directed: classic border with gap scores, garbage interior
    for (int a = 0; a < N; a++) begin
      int r, c;
      r = a / COLS; c = a % COLS;
      init_m[a] = (r == 0) ? 16'(-2*c) : (c == 0) ? 16'(-2*r) : 16'sh0bad;
      ref_m[a]  = ((a % 3) == 0) ? 16'sd1 : -16'sd1;
    end
    load_all();
    read(2*COLS+3, v);
    chk("R2 interior load readback", int'(v), int'(16'sh0bad));
    sweep(0, 16'sd2);

    // directed: zero penalty, all zero
    for (int a = 0; a < N; a++) begin init_m[a] = '0; ref_m[a] = '0; end
    load_all();
    sweep(0, 16'sd0);

    // directed: wraparound at the positive limit
    for (int a = 0; a < N; a++) begin init_m[a] = 16'sh7ff0; ref_m[a] = 16'sh0100; end
    load_all();
    sweep(0, -16'sd3);

    // random sweeps
    for (int n = 0; n < 3; n++) begin
      fill_random((n == 2) ? 0 : 200);
      load_all();
      sweep(0, 16'($urandom % 16));
    end

    // start during a sweep
    fill_random(100);
    load_all();
    sweep(1, 16'sd4);

    // loads during a sweep
    fill_random(100);
    load_all();
    sweep(2, 16'sd3);

    // penalty change during a sweep
    fill_random(100);
    load_all();
    sweep(3, 16'sd5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule